// File: doc/BRIEF.md
# ADC Mid-Scale Offset Calibrator

This block works out the offset error of a 10-bit converter. A one-cycle start pulse puts it into calibration. It then drives a control output that forces the converter input to half of the reference. After a programmable settling time, counted in bus clocks, it adds up sixteen fresh readings from channel 0, taking one reading on each sample strobe. It divides the sum by sixteen with a right shift and subtracts that average from the ideal mid-scale code, 512. The signed result is kept in a register, where it can be added to later raw readings. When the result is valid, the force output drops and a done flag rises.

A companion path scales readings that come back from the converter. When battery sensing is on and the reading belongs to channel 7, the path multiplies both the raw code and the stored offset by three. It then divides them by one or by two, as a divider-select input chooses. Readings from any other channel pass through unscaled, together with the plain offset.

Top module: `adc_offset_cal`

## Requirements
- R1: While reset is high and in the cycle after it is released, `force_mid`, `cal_busy`, `cal_done` and `out_valid` are 0 and `comp_value` is 0.
- R2: A `cal_start` pulse seen while idle sets `force_mid` and `cal_busy` and clears `cal_done`, all in the next cycle.
- R3: Sample strobes that arrive within `settle_cycles`+1 cycles after the start edge are not accumulated and have no effect on the result.
- R4: Exactly 16 accepted samples are summed without overflow. The average is the sum shifted right by 4, truncating. `comp_value` is 512 minus that average, as an 11-bit two's-complement number (range -511 to +512).
- R5: One cycle after the clock edge that takes the 16th sample, `cal_done` goes to 1 and `comp_value` takes the new result. In that same cycle `force_mid` and `cal_busy` return to 0.
- R6: A `cal_start` pulse seen while a calibration is running is ignored. The running calibration finishes with its own samples.
- R7: After completion, `comp_value` and `cal_done` hold until the next accepted start, and further strobes change neither.
- R8: One cycle after `rd_valid`, `out_valid` is 1 for exactly one cycle. If `bat_en` is 0 or `rd_chan` is not 7, `out_data` equals `rd_data` and `out_offset` equals `comp_value`, sign-extended.
- R9: With `bat_en`=1, `rd_chan`=7 and `div_sel`=1, `out_data` is `rd_data`*3 and `out_offset` is `comp_value`*3.
- R10: With `bat_en`=1, `rd_chan`=7 and `div_sel`=0, `out_data` is `rd_data`*3/2 and `out_offset` is `comp_value`*3/2, both truncated toward zero (so -1533 gives -766).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | One-cycle request to start a calibration |
| settle_cycles | input | 16 | Settling delay in bus clocks |
| smp_strobe | input | 1 | One-cycle pulse marking a fresh channel-0 sample |
| smp_data | input | 10 | Channel-0 conversion result |
| force_mid | output | 1 | Forces the converter input to half of the reference |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Offset value is valid |
| comp_value | output | 11 | Signed offset, 512 minus the average |
| bat_en | input | 1 | Battery sensing active on channel 7 |
| div_sel | input | 1 | 1: gain 3/1, 0: gain 3/2 |
| rd_valid | input | 1 | Reading to be scaled is present |
| rd_chan | input | 3 | Channel number of the reading |
| rd_data | input | 10 | Raw reading |
| out_valid | output | 1 | Scaled outputs valid |
| out_data | output | 12 | Scaled reading |
| out_offset | output | 12 | Scaled signed offset |

## Verification
The force and busy outputs respond one cycle after an accepted start. The done flag and the new offset appear one cycle after the edge that takes the sixteenth sample. Scaled readings appear one cycle after `rd_valid`. The bench drives each input on a falling edge and reads the matching output on the falling edge at which that result is due. It also checks the cycle before the done flag rises, to make sure the flag is not early. Strobes sent during settling, and a start sent in the middle of a calibration, are judged only by the final offset, which the bench works out from the samples it actually meant to be counted.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SETTLE = 2'd1,
    CAL_ACQ    = 2'd2,
    CAL_FINISH = 2'd3
  } cal_state_t;
endpackage

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl #(
  parameter int SETTLE_W   = 16,
  parameter int NSAMP_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                strobe,
  output logic                force_mid,
  output logic                busy,
  output logic                done,
  output logic                acc_clear,
  output logic                acc_en,
  output logic                finish
);
  import adc_cal_pkg::*;

  localparam logic [NSAMP_LOG2-1:0] LAST_SMP = {NSAMP_LOG2{1'b1}};

  cal_state_t            state;
  logic [SETTLE_W-1:0]   settle_cnt;
  logic [NSAMP_LOG2-1:0] smp_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CAL_IDLE;
      settle_cnt <= '0;
      smp_cnt    <= '0;
      force_mid  <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (state)
        CAL_IDLE: begin
          if (start) begin
            state      <= CAL_SETTLE;
            settle_cnt <= settle_cycles;
            smp_cnt    <= '0;
            force_mid  <= 1'b1;
            done       <= 1'b0;
          end
        end
        CAL_SETTLE: begin
          if (settle_cnt == '0) state <= CAL_ACQ;
          else                  settle_cnt <= settle_cnt - 1'b1;
        end
        CAL_ACQ: begin
          if (strobe) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (smp_cnt == LAST_SMP) state <= CAL_FINISH;
          end
        end
        CAL_FINISH: begin
          state     <= CAL_IDLE;
          force_mid <= 1'b0;
          done      <= 1'b1;
        end
        default: state <= CAL_IDLE;
      endcase
    end
  end

  assign busy      = (state != CAL_IDLE);
  assign acc_clear = (state == CAL_IDLE) && start;
  assign acc_en    = (state == CAL_ACQ) && strobe;
  assign finish    = (state == CAL_FINISH);
endmodule

// File: rtl/adc_cal_accum.sv
module adc_cal_accum #(
  parameter int DATA_W     = 10,
  parameter int NSAMP_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     en,
  input  logic [DATA_W-1:0]        data,
  input  logic                     finish,
  output logic signed [DATA_W:0]   comp
);
  localparam int ACC_W = DATA_W + NSAMP_LOG2;
  localparam int OFF_W = DATA_W + 1;
  localparam logic [OFF_W-1:0] MID_CODE = OFF_W'(1) << (DATA_W - 1);

  logic [ACC_W-1:0]  acc;
  logic [DATA_W-1:0] avg;
  logic [OFF_W-1:0]  diff;

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (en)      acc <= acc + {{NSAMP_LOG2{1'b0}}, data};
  end

  assign avg  = acc[ACC_W-1:NSAMP_LOG2];
  assign diff = MID_CODE - {1'b0, avg};

  always_ff @(posedge clk) begin
    if (rst)         comp <= '0;
    else if (finish) comp <= $signed(diff);
  end
endmodule

// File: rtl/adc_gain_scaler.sv
module adc_gain_scaler #(
  parameter int DATA_W      = 10,
  parameter int CH_W        = 3,
  parameter int BAT_CHAN    = 7,
  parameter bit BAT_SUPPORT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bat_en,
  input  logic                      div_sel,
  input  logic signed [DATA_W:0]    comp,
  input  logic                      rd_valid,
  input  logic [CH_W-1:0]           rd_chan,
  input  logic [DATA_W-1:0]         rd_data,
  output logic                      out_valid,
  output logic [DATA_W+1:0]         out_data,
  output logic signed [DATA_W+1:0]  out_offset
);
  localparam int OUT_W  = DATA_W + 2;
  localparam int SOFF_W = DATA_W + 2;
  localparam logic signed [SOFF_W-1:0] ONE_S = 1;

  logic [OUT_W-1:0]         nxt_data;
  logic signed [SOFF_W-1:0] nxt_off;
  logic signed [SOFF_W-1:0] off_ext;
  logic [OUT_W-1:0]         raw_ext;

  assign off_ext = {comp[DATA_W], comp};
  assign raw_ext = {2'b00, rd_data};

  generate
    if (BAT_SUPPORT) begin : g_bat
      logic                     apply;
      logic [OUT_W-1:0]         raw3;
      logic signed [SOFF_W-1:0] off3;
      logic signed [SOFF_W-1:0] off3_half;

      assign apply     = bat_en && (rd_chan == CH_W'(BAT_CHAN));
      assign raw3      = raw_ext + (raw_ext << 1);
      assign off3      = off_ext + (off_ext <<< 1);
      assign off3_half = off3[SOFF_W-1] ? ((off3 + ONE_S) >>> 1) : (off3 >>> 1);

      always_comb begin
        if (!apply) begin
          nxt_data = raw_ext;
          nxt_off  = off_ext;
        end else if (div_sel) begin
          nxt_data = raw3;
          nxt_off  = off3;
        end else begin
          nxt_data = raw3 >> 1;
          nxt_off  = off3_half;
        end
      end
    end else begin : g_plain
      logic unused_sel;
      assign unused_sel = bat_en ^ div_sel ^ (^rd_chan);
      assign nxt_data   = raw_ext;
      assign nxt_off    = off_ext;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_offset <= '0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) begin
        out_data   <= nxt_data;
        out_offset <= nxt_off;
      end
    end
  end
endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal #(
  parameter int DATA_W      = 10,
  parameter int NSAMP_LOG2  = 4,
  parameter int SETTLE_W    = 16,
  parameter int CH_W        = 3,
  parameter int BAT_CHAN    = 7,
  parameter bit BAT_SUPPORT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cal_start,
  input  logic [SETTLE_W-1:0]       settle_cycles,
  input  logic                      smp_strobe,
  input  logic [DATA_W-1:0]         smp_data,
  output logic                      force_mid,
  output logic                      cal_busy,
  output logic                      cal_done,
  output logic signed [DATA_W:0]    comp_value,
  input  logic                      bat_en,
  input  logic                      div_sel,
  input  logic                      rd_valid,
  input  logic [CH_W-1:0]           rd_chan,
  input  logic [DATA_W-1:0]         rd_data,
  output logic                      out_valid,
  output logic [DATA_W+1:0]         out_data,
  output logic signed [DATA_W+1:0]  out_offset
);
  logic acc_clear, acc_en, finish;

  adc_cal_ctrl #(.SETTLE_W(SETTLE_W), .NSAMP_LOG2(NSAMP_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .start(cal_start), .settle_cycles(settle_cycles),
    .strobe(smp_strobe), .force_mid(force_mid), .busy(cal_busy),
    .done(cal_done), .acc_clear(acc_clear), .acc_en(acc_en), .finish(finish)
  );

  adc_cal_accum #(.DATA_W(DATA_W), .NSAMP_LOG2(NSAMP_LOG2)) u_accum (
    .clk(clk), .rst(rst), .clear(acc_clear), .en(acc_en), .data(smp_data),
    .finish(finish), .comp(comp_value)
  );

  adc_gain_scaler #(.DATA_W(DATA_W), .CH_W(CH_W), .BAT_CHAN(BAT_CHAN),
                    .BAT_SUPPORT(BAT_SUPPORT)) u_scale (
    .clk(clk), .rst(rst), .bat_en(bat_en), .div_sel(div_sel),
    .comp(comp_value), .rd_valid(rd_valid), .rd_chan(rd_chan),
    .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_offset(out_offset)
  );
endmodule

// File: rtl/adc_offset_cal_chk.sv
module adc_offset_cal_chk #(
  parameter int DATA_W = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cal_start,
  input logic                   cal_busy,
  input logic                   force_mid,
  input logic                   cal_done,
  input logic signed [DATA_W:0] comp_value,
  input logic                   rd_valid,
  input logic                   out_valid
);
  localparam int MID = 1 << (DATA_W - 1);

  // R2
  start_forces_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_start && !cal_busy) |=> (force_mid && cal_busy && !cal_done));

  // R5
  done_releases_chk: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (!force_mid && !cal_busy));

  // R4
  comp_range_chk: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> ((int'(comp_value) <= MID) && (int'(comp_value) >= -(MID - 1))));

  // R7
  comp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(cal_done) |-> $stable(comp_value));

  // R8
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> out_valid);

  // R8
  out_single_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !out_valid);
endmodule

bind adc_offset_cal adc_offset_cal_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cal_start(cal_start), .cal_busy(cal_busy),
  .force_mid(force_mid), .cal_done(cal_done), .comp_value(comp_value),
  .rd_valid(rd_valid), .out_valid(out_valid)
);

// File: tb/tb_adc_offset_cal.sv
`timescale 1ns/1ps
module tb_adc_offset_cal;
  logic               clk = 1'b0;
  logic               rst;
  logic               cal_start;
  logic [15:0]        settle_cycles;
  logic               smp_strobe;
  logic [9:0]         smp_data;
  logic               force_mid, cal_busy, cal_done;
  logic signed [10:0] comp_value;
  logic               bat_en, div_sel, rd_valid;
  logic [2:0]         rd_chan;
  logic [9:0]         rd_data;
  logic               out_valid;
  logic [11:0]        out_data;
  logic signed [11:0] out_offset;

  int checks = 0;
  int fails  = 0;
  int last_comp = 0;

  always #2 clk = ~clk;

  adc_offset_cal dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .settle_cycles(settle_cycles),
    .smp_strobe(smp_strobe), .smp_data(smp_data), .force_mid(force_mid),
    .cal_busy(cal_busy), .cal_done(cal_done), .comp_value(comp_value),
    .bat_en(bat_en), .div_sel(div_sel), .rd_valid(rd_valid),
    .rd_chan(rd_chan), .rd_data(rd_data), .out_valid(out_valid),
    .out_data(out_data), .out_offset(out_offset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int mode, input int i);
    case (mode)
      0: return 512;
      1: return 0;
      2: return 1023;
      3: return i * 64 + 5;
      default: return 500 + i;
    endcase
  endfunction

  function automatic int expect_comp(input int mode);
    int sum = 0;
    for (int i = 0; i < 16; i++) sum += pat(mode, i);
    return 512 - (sum >>> 4);
  endfunction

  task automatic strobe_one(input int val);
    smp_strobe = 1'b1; smp_data = 10'(val);
    @(negedge clk);
    smp_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start(input int settle);
    settle_cycles = 16'(settle);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  // Feeds samples idx_lo..15; the 16th checks done timing (R5)
  task automatic feed_tail(input int mode, input int idx_lo, input string req);
    for (int i = idx_lo; i < 16; i++) begin
      if (i < 15) strobe_one(pat(mode, i));
      else begin
        smp_strobe = 1'b1; smp_data = 10'(pat(mode, i));
        @(negedge clk);
        smp_strobe = 1'b0;
        chk("R5 done not early", int'(cal_done), 0);
        @(negedge clk);
        chk("R5 done", int'(cal_done), 1);
        chk("R5 force released", int'(force_mid), 0);
        chk("R5 busy released", int'(cal_busy), 0);
        chk(req, int'(comp_value), expect_comp(mode));
      end
    end
    last_comp = expect_comp(mode);
  endtask

  task automatic t_reset();
    chk("R1 force", int'(force_mid), 0);
    chk("R1 busy", int'(cal_busy), 0);
    chk("R1 done", int'(cal_done), 0);
    chk("R1 comp", int'(comp_value), 0);
    chk("R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_cal(input int mode, input int settle);
    pulse_start(settle);
    chk("R2 force", int'(force_mid), 1);
    chk("R2 busy", int'(cal_busy), 1);
    chk("R2 done cleared", int'(cal_done), 0);
    repeat (settle + 5) @(negedge clk);
    feed_tail(mode, 0, "R4 comp");
  endtask

  task automatic t_settle_ignore();
    pulse_start(40);
    for (int i = 0; i < 10; i++) strobe_one(1023);
    repeat (20) @(negedge clk);
    feed_tail(0, 0, "R3 settle strobes ignored");
  endtask

  task automatic t_busy_start();
    pulse_start(10);
    repeat (15) @(negedge clk);
    for (int i = 0; i < 8; i++) strobe_one(pat(3, i));
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk("R6 still busy", int'(cal_busy), 1);
    feed_tail(3, 8, "R6 start ignored");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 6; i++) strobe_one(3);
    chk("R7 comp held", int'(comp_value), last_comp);
    chk("R7 done held", int'(cal_done), 1);
  endtask

  task automatic t_scale(input bit be, input bit ds, input int ch, input int d,
                         input string req);
    bit apply = be && (ch == 7);
    int ed = apply ? (ds ? d * 3 : (d * 3) / 2) : d;
    int eo = apply ? (ds ? last_comp * 3 : (last_comp * 3) / 2) : last_comp;
    bat_en = be; div_sel = ds; rd_chan = 3'(ch); rd_data = 10'(d);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " data"}, int'(out_data), ed);
    chk({req, " offset"}, int'(out_offset), eo);
    @(negedge clk);
    chk("R8 single valid", int'(out_valid), 0);
  endtask

  initial begin
    rst = 1'b1; cal_start = 1'b0; settle_cycles = '0; smp_strobe = 1'b0;
    smp_data = '0; bat_en = 1'b0; div_sel = 1'b0; rd_valid = 1'b0;
    rd_chan = '0; rd_data = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cal(3, 20);
    t_hold();
    t_scale(1'b0, 1'b1, 7, 700, "R8 bat off");
    t_scale(1'b1, 1'b1, 3, 700, "R8 other chan");
    t_scale(1'b1, 1'b1, 7, 701, "R9 gain 3");
    t_scale(1'b1, 1'b0, 7, 701, "R10 gain 3/2");
    t_cal(2, 0);
    t_scale(1'b1, 1'b0, 7, 1023, "R10 negative offset");
    t_scale(1'b1, 1'b1, 7, 1023, "R9 negative offset");
    t_cal(1, 5);
    t_scale(1'b1, 1'b1, 7, 0, "R9 max offset");
    t_cal(0, 3);
    t_cal(4, 7);
    t_settle_ignore();
    t_busy_start();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule